// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the timing controller of an integrating (dual-slope) analog-to-digital converter. It steps the converter through a repeating cycle with three phases. The first is an offset-nulling phase (auto-zero). The second integrates the input signal for a fixed number of clocks. The third integrates the reference back toward zero and counts clocks until the comparator reports a zero crossing. The analog parts are outside the block. The comparator arrives as a plain digital `zero_cross_i` flag, the input sign as `sign_i`, and the switch controls leave as three phase-select outputs.

A run/hold input governs pacing. If it is held high, the block converts back to back and spends only the minimum time in auto-zero. If it is low when the minimum auto-zero time ends, the block parks in auto-zero. Once it returns high, integration starts after a fixed restart delay. If run/hold is low after the zero crossing has been seen, the reference phase ends early and the remainder of its maximum length is skipped. The result count, polarity and overrange flag sit in an output latch. That latch changes only in the cycle where `status_o` falls, so a reader that waits for `status_o` low always sees a settled value.

Top module: `dss_sequencer`

## Requirements
- R1: The phases always run in the order auto-zero, integrate, deintegrate, auto-zero, and exactly one of the three phase outputs is high in every cycle.
- R2: A low level on `run_hold_i` during the first `AZ_MIN` cycles of auto-zero has no effect: if the input is high again when the minimum ends, integration still begins after exactly `AZ_MIN` auto-zero cycles.
- R3: With `run_hold_i` high, auto-zero lasts exactly `AZ_MIN` cycles, and `status_o` rises in the same cycle that integration begins.
- R4: If no zero crossing is seen, deintegrate lasts exactly `DEINT_MAX` cycles and then latches `overrange_o`=1 and `result_o`=`DEINT_MAX`.
- R5: If the zero crossing is sampled at deintegrate count k and `run_hold_i` is low on the following clock edge, deintegrate ends after k+2 cycles (capped at `DEINT_MAX`).
- R6: If `run_hold_i` is low when the minimum auto-zero time ends, the block stays in auto-zero with `status_o` low for as long as the input stays low.
- R7: From the parked state, the rising clock edge that first samples `run_hold_i` high is followed by exactly `START_DLY` (7) more edges before `status_o` rises and integration begins.
- R8: `result_o`, `polarity_o` and `overrange_o` change only in the cycle where `status_o` falls, and hold steady while `status_o` is high.
- R9: Integration lasts exactly `INT_LEN` cycles.
- R10: The result is the deintegrate count k at the edge that first samples `zero_cross_i` high. The first deintegrate cycle counts as 0, and `overrange_o` is 0. Crossings seen outside deintegrate, and any crossing after the first, are ignored.
- R11: `polarity_o` equals `sign_i` as sampled in the last integrate cycle.
- R12: A synchronous active-high `rst` puts the block in auto-zero with `status_o`, `result_o`, `polarity_o` and `overrange_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_hold_i | input | 1 | High: convert; low: end deintegrate after crossing and park in auto-zero |
| zero_cross_i | input | 1 | Comparator zero-crossing flag |
| sign_i | input | 1 | Input sign from the analog front end |
| phase_az_o | output | 1 | Auto-zero phase select |
| phase_int_o | output | 1 | Signal integrate phase select |
| phase_deint_o | output | 1 | Reference deintegrate phase select |
| status_o | output | 1 | High while a conversion is in progress |
| result_o | output | RES_W | Latched conversion count |
| polarity_o | output | 1 | Latched input sign |
| overrange_o | output | 1 | Latched flag: no crossing within the limit |

## Verification
The bench builds the block with `AZ_MIN`=20, `INT_LEN`=32, `DEINT_MAX`=25 and `START_DLY`=7. With these values each conversion lasts about a hundred cycles, so dozens of conversions fit in one run. The short deintegrate limit lets random crossing positions land before the limit, on its last cycle and past it, so the overrange case comes up often. The short auto-zero makes parked waits and early-terminated runs cheap to mix freely.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_AZ    = 3'd0,
        ST_WAIT  = 3'd1,
        ST_START = 3'd2,
        ST_INT   = 3'd3,
        ST_DEINT = 3'd4
    } phase_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dss_phase_ctrl.sv
module dss_phase_ctrl
    import dss_pkg::*;
#(
    parameter int AZ_MIN    = 1790,
    parameter int INT_LEN   = 2048,
    parameter int DEINT_MAX = 2041,
    parameter int START_DLY = 7,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_hold_i,
    input  logic             zc_seen_i,
    output phase_e           st_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             int_start_o,
    output logic             int_done_o,
    output logic             deint_done_o
);

    localparam logic [CNT_W-1:0] AZ_LAST    = CNT_W'(AZ_MIN - 1);
    localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(INT_LEN - 1);
    localparam logic [CNT_W-1:0] DEINT_LAST = CNT_W'(DEINT_MAX - 1);
    localparam logic [CNT_W-1:0] DLY_LAST   = CNT_W'(START_DLY);

    typedef struct packed {
        phase_e           st;
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  int_start_d, int_done_d, deint_done_d;

    always_comb begin
        ctrl_d       = ctrl_q;
        int_start_d  = 1'b0;
        int_done_d   = 1'b0;
        deint_done_d = 1'b0;
        unique case (ctrl_q.st)
            ST_AZ: begin
                if (ctrl_q.cnt == AZ_LAST) begin
                    if (run_hold_i) begin
                        ctrl_d.st   = ST_INT;
                        ctrl_d.cnt  = '0;
                        int_start_d = 1'b1;
                    end else begin
                        ctrl_d.st = ST_WAIT;
                    end
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (run_hold_i) begin
                    ctrl_d.st  = ST_START;
                    ctrl_d.cnt = CNT_W'(1);
                end
            end
            ST_START: begin
                if (ctrl_q.cnt == DLY_LAST) begin
                    ctrl_d.st   = ST_INT;
                    ctrl_d.cnt  = '0;
                    int_start_d = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_INT: begin
                if (ctrl_q.cnt == INT_LAST) begin
                    ctrl_d.st  = ST_DEINT;
                    ctrl_d.cnt = '0;
                    int_done_d = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_DEINT: begin
                if (ctrl_q.cnt == DEINT_LAST || (zc_seen_i && !run_hold_i)) begin
                    ctrl_d.st    = ST_AZ;
                    ctrl_d.cnt   = '0;
                    deint_done_d = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctrl_d.st  = ST_AZ;
                ctrl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.st  <= ST_AZ;
            ctrl_q.cnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign st_o         = ctrl_q.st;
    assign cnt_o        = ctrl_q.cnt;
    assign int_start_o  = int_start_d;
    assign int_done_o   = int_done_d;
    assign deint_done_o = deint_done_d;

    // R6: a parked converter stays parked while run/hold is low
    assert_park_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.st == ST_WAIT && !run_hold_i) |=> (ctrl_q.st == ST_WAIT));

    // R7: the restart delay count stays inside its window
    assert_start_window_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.st == ST_START) |-> (ctrl_q.cnt >= CNT_W'(1) && ctrl_q.cnt <= DLY_LAST));

endmodule

// File: rtl/dss_result_latch.sv
module dss_result_latch #(
    parameter int DEINT_MAX = 2041,
    parameter int CNT_W     = 12,
    parameter int RES_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zero_cross_i,
    input  logic             sign_i,
    input  logic             in_deint_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             int_start_i,
    input  logic             int_done_i,
    input  logic             deint_done_i,
    output logic             zc_seen_o,
    output logic             status_o,
    output logic [RES_W-1:0] result_o,
    output logic             polarity_o,
    output logic             overrange_o
);

    localparam logic [RES_W-1:0] OVR_CODE = RES_W'(DEINT_MAX);

    typedef struct packed {
        logic             zc_seen;
        logic [RES_W-1:0] cap;
        logic             pol_pend;
        logic             status;
        logic [RES_W-1:0] result;
        logic             pol;
        logic             ovr;
    } lat_s;

    lat_s lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (int_start_i) begin
            lat_d.status = 1'b1;
        end
        if (int_done_i) begin
            lat_d.pol_pend = sign_i;
            lat_d.zc_seen  = 1'b0;
        end
        if (in_deint_i && !lat_q.zc_seen && zero_cross_i) begin
            lat_d.zc_seen = 1'b1;
            lat_d.cap     = RES_W'(cnt_i);
        end
        if (deint_done_i) begin
            lat_d.status  = 1'b0;
            lat_d.pol     = lat_q.pol_pend;
            lat_d.zc_seen = 1'b0;
            if (lat_q.zc_seen) begin
                lat_d.result = lat_q.cap;
                lat_d.ovr    = 1'b0;
            end else if (zero_cross_i) begin
                lat_d.result = RES_W'(cnt_i);
                lat_d.ovr    = 1'b0;
            end else begin
                lat_d.result = OVR_CODE;
                lat_d.ovr    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign zc_seen_o   = lat_q.zc_seen;
    assign status_o    = lat_q.status;
    assign result_o    = lat_q.result;
    assign polarity_o  = lat_q.pol;
    assign overrange_o = lat_q.ovr;

    // R8: latched outputs settle while a conversion is running
    assert_latch_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (lat_q.status && $past(lat_q.status)) |->
            ($stable(lat_q.result) && $stable(lat_q.pol) && $stable(lat_q.ovr)));

    // R10: a crossing is only ever recorded during deintegrate
    assert_zc_in_deint_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(lat_q.zc_seen) |-> $past(in_deint_i));

endmodule

// File: rtl/dss_sequencer.sv
module dss_sequencer
    import dss_pkg::*;
#(
    parameter int AZ_MIN    = 1790,
    parameter int INT_LEN   = 2048,
    parameter int DEINT_MAX = 2041,
    parameter int START_DLY = 7,
    parameter int RES_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_hold_i,
    input  logic             zero_cross_i,
    input  logic             sign_i,
    output logic             phase_az_o,
    output logic             phase_int_o,
    output logic             phase_deint_o,
    output logic             status_o,
    output logic [RES_W-1:0] result_o,
    output logic             polarity_o,
    output logic             overrange_o
);

    localparam int CNT_MAX = max_of4(AZ_MIN, INT_LEN, DEINT_MAX, START_DLY + 1);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int LEN_W   = CNT_W + 1;

    phase_e           st;
    logic [CNT_W-1:0] cnt;
    logic             int_start, int_done, deint_done, zc_seen;

    dss_phase_ctrl #(
        .AZ_MIN    (AZ_MIN),
        .INT_LEN   (INT_LEN),
        .DEINT_MAX (DEINT_MAX),
        .START_DLY (START_DLY),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .run_hold_i   (run_hold_i),
        .zc_seen_i    (zc_seen),
        .st_o         (st),
        .cnt_o        (cnt),
        .int_start_o  (int_start),
        .int_done_o   (int_done),
        .deint_done_o (deint_done)
    );

    dss_result_latch #(
        .DEINT_MAX (DEINT_MAX),
        .CNT_W     (CNT_W),
        .RES_W     (RES_W)
    ) u_latch (
        .clk          (clk),
        .rst          (rst),
        .zero_cross_i (zero_cross_i),
        .sign_i       (sign_i),
        .in_deint_i   (st == ST_DEINT),
        .cnt_i        (cnt),
        .int_start_i  (int_start),
        .int_done_i   (int_done),
        .deint_done_i (deint_done),
        .zc_seen_o    (zc_seen),
        .status_o     (status_o),
        .result_o     (result_o),
        .polarity_o   (polarity_o),
        .overrange_o  (overrange_o)
    );

    assign phase_az_o    = (st == ST_AZ) || (st == ST_WAIT) || (st == ST_START);
    assign phase_int_o   = (st == ST_INT);
    assign phase_deint_o = (st == ST_DEINT);

    // Independent phase-length counters used only by the assertions below
    logic [LEN_W-1:0] az_len_d, az_len_q, de_len_d, de_len_q;

    always_comb begin
        az_len_d = phase_az_o ? ((&az_len_q) ? az_len_q : az_len_q + 1'b1) : '0;
        de_len_d = phase_deint_o ? ((&de_len_q) ? de_len_q : de_len_q + 1'b1) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            az_len_q <= '0;
            de_len_q <= '0;
        end else begin
            az_len_q <= az_len_d;
            de_len_q <= de_len_d;
        end
    end

    // R1: one phase at a time
    assert_one_phase_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot({phase_az_o, phase_int_o, phase_deint_o}));

    // R1: deintegrate is only entered from integrate
    assert_deint_after_int_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_deint_o) |-> $past(phase_int_o));

    // R3: auto-zero is never left before its minimum length
    assert_az_minimum_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_az_o) |-> (az_len_q >= LEN_W'(AZ_MIN)));

    // R4: deintegrate never outlasts its limit
    assert_deint_limit_R4: assert property (@(posedge clk) disable iff (rst)
        phase_deint_o |-> (de_len_q < LEN_W'(DEINT_MAX)));

    // R8: status falls only when deintegrate ends
    assert_status_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o) |-> ($past(phase_deint_o) && phase_az_o));

endmodule

// File: tb/dss_sequencer_bench.sv
`timescale 1ns/1ps
module dss_sequencer_bench;

    localparam int AZ_MIN    = 20;
    localparam int INT_LEN   = 32;
    localparam int DEINT_MAX = 25;
    localparam int START_DLY = 7;
    localparam int RES_W     = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rh  = 1'b1;
    logic zc  = 1'b0;
    logic sgn = 1'b0;
    logic ph_az, ph_int, ph_de, status, pol, ovr;
    logic [RES_W-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dss_sequencer #(
        .AZ_MIN    (AZ_MIN),
        .INT_LEN   (INT_LEN),
        .DEINT_MAX (DEINT_MAX),
        .START_DLY (START_DLY),
        .RES_W     (RES_W)
    ) u_dss_sequencer (
        .clk           (clk),
        .rst           (rst),
        .run_hold_i    (rh),
        .zero_cross_i  (zc),
        .sign_i        (sgn),
        .phase_az_o    (ph_az),
        .phase_int_o   (ph_int),
        .phase_deint_o (ph_de),
        .status_o      (status),
        .result_o      (result),
        .polarity_o    (pol),
        .overrange_o   (ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int exp_res(input int k);
        return (k < DEINT_MAX) ? k : DEINT_MAX;
    endfunction

    function automatic int exp_ovr(input int k);
        return (k >= DEINT_MAX) ? 1 : 0;
    endfunction

    function automatic int exp_len(input int k, input bit early);
        if (k < DEINT_MAX && early) return (k + 2 < DEINT_MAX) ? k + 2 : DEINT_MAX;
        return DEINT_MAX;
    endfunction

    // Called at the first falling edge of an auto-zero phase.
    task automatic conv(input int k, input bit early, input bit s,
                        input bit park, input int extra, input bit glitch);
        int old_res;
        int n;
        if (!park) begin
            rh = 1'b1;
            if (glitch) begin
                repeat (2) tick();
                rh = 1'b0;
                tick();
                rh = 1'b1;
                repeat (AZ_MIN - 4) tick();
            end else begin
                repeat (AZ_MIN - 1) tick();
            end
            chk(!status && ph_az, glitch ? "R2 still in auto-zero" : "R3 still in auto-zero",
                status, 0);
            tick();
            chk(status && ph_int, glitch ? "R2 start not delayed" : "R3 start after minimum",
                {ph_int, status}, 3);
        end else begin
            rh = 1'b0;
            repeat (AZ_MIN + extra) tick();
            chk(!status && ph_az, "R6 parked in auto-zero", {ph_az, status}, 2);
            rh = 1'b1;
            repeat (START_DLY) tick();
            chk(!status && ph_az, "R7 no start before delay", status, 0);
            tick();
            chk(status && ph_int, "R7 start after delay", {ph_int, status}, 3);
        end
        // integrate phase, falling edge 0
        old_res = int'(result);
        sgn = ~s;
        repeat (3) tick();
        zc = 1'b1;                    // R10: crossing during integrate is ignored
        tick();
        zc = 1'b0;
        repeat (INT_LEN - 5) tick();
        chk(ph_int && !ph_de, "R9 integrate still running", ph_int, 1);
        sgn = s;
        tick();
        sgn = ~s;
        chk(ph_de && !ph_int && !ph_az, "R9 R1 deintegrate begins", {ph_az, ph_int, ph_de}, 1);
        // deintegrate phase
        n = 0;
        while (status && n < DEINT_MAX + 5) begin
            chk(int'(result) == old_res, "R8 result held during conversion", int'(result), old_res);
            if (n == k && k < DEINT_MAX) begin
                zc = 1'b1;
                if (early) rh = 1'b0;
            end else if (n == k + 1 && !early) begin
                zc = 1'b1;            // R10: second crossing ignored
            end
            tick();
            zc = 1'b0;
            n++;
        end
        chk(n == exp_len(k, early), early ? "R5 early deintegrate end" : "R4 deintegrate length",
            n, exp_len(k, early));
        chk(ph_az && !ph_int && !ph_de, "R1 back to auto-zero", {ph_az, ph_int, ph_de}, 4);
        chk(int'(result) == exp_res(k), (k < DEINT_MAX) ? "R10 result count" : "R4 overrange code",
            int'(result), exp_res(k));
        chk(int'(ovr) == exp_ovr(k), "R4 R10 overrange flag", ovr, exp_ovr(k));
        chk(pol == s, "R11 polarity", pol, s);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        repeat (3) tick();
        chk(ph_az && !ph_int && !ph_de, "R12 reset phase", {ph_az, ph_int, ph_de}, 4);
        chk(!status, "R12 reset status", status, 0);
        chk(result == '0 && !pol && !ovr, "R12 reset latch", int'(result), 0);
        rst = 1'b0;

        // directed corner cases
        conv(5, 1'b0, 1'b1, 1'b0, 0, 1'b0);
        conv(0, 1'b1, 1'b0, 1'b0, 0, 1'b1);
        conv(DEINT_MAX - 1, 1'b0, 1'b1, 1'b1, 3, 1'b0);
        conv(DEINT_MAX, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        conv(DEINT_MAX + 2, 1'b0, 1'b1, 1'b1, 1, 1'b0);
        conv(DEINT_MAX - 3, 1'b1, 1'b1, 1'b1, 8, 1'b0);

        // constrained random conversions
        for (int i = 0; i < 24; i++) begin
            int  k;
            bit  early;
            k     = int'($urandom % (DEINT_MAX + 4));
            early = (k <= DEINT_MAX - 3) && ($urandom % 2 == 1);
            conv(k, early, bit'($urandom % 2), ($urandom % 3) == 0,
                 int'($urandom % 10) + 1, bit'($urandom % 2));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule